// File: doc/BRIEF.md
# Trellis Add-Compare-Select Unit (64 states, rate 1/2)

This block holds the accumulated path metrics of a 64-state trellis for a rate-1/2 convolutional code of constraint length 7 with generator taps 171 and 133 (octal). For every received symbol it accepts four branch metrics, one per possible pair of coded bits. It then sweeps the trellis eight states per clock. Each state adds the proper branch metric to the metrics of its two predecessors and keeps the smaller sum. It also records which predecessor won as one decision bit. A whole trellis step therefore takes eight cycles.

When a step finishes, the block pulses a done strobe for one cycle. It presents the 64 decision bits of that step and the index of the state with the lowest new metric. A traceback stage downstream consumes these outputs. Branch metrics arrive on a valid/ready input. The sender must hold `bm_data` and `bm_valid` steady until a cycle in which `bm_ready` is high. `bm_ready` falls for the first seven cycles of each step and rises again in the step's last cycle, so symbols can be streamed back to back. The result side has no back-pressure: the consumer must capture `dec_bits` and `best_state` in the cycle that `dec_valid` is high.

Top module: `trellis_acs_unit`

## Requirements
- R1: After reset, `bm_ready` is 1, `dec_valid` is 0, `best_state` is 0 and `dec_bits` is all zeros. State 0 holds metric 0 and every other state holds metric 256.
- R2: A symbol is taken on a rising edge where `bm_valid` and `bm_ready` are both 1. `bm_ready` is 0 in the seven cycles that follow an accepting edge and is 1 in the eighth.
- R3: `dec_valid` is high for exactly one cycle, starting on the eighth rising edge after the accepting edge. It never rises without a preceding accepted symbol.
- R4: The state word is 6 bits wide and the newest input bit enters at bit 5. The predecessors of state s are p0=(2s mod 64) and p1=p0+1. The transition from p to s uses the 7-bit window w={s[5],p[5:0]}. Its coded pair is c=2*parity(w&1111001b)+parity(w&1011011b), and it uses branch metric lane c, found at `bm_data[4c+3:4c]`.
- R5: Each new metric is min(old[p0]+bm, old[p1]+bm). Bit s of `dec_bits` is 1 when the p1 sum is strictly smaller than the p0 sum.
- R6: When the two sums are equal, p0 wins and the decision bit is 0.
- R7: `best_state` is the state with the smallest new metric in the step. Among equal metrics, the lowest index wins. It changes only in the cycle `dec_valid` rises.
- R8: Metrics are 10-bit. When a step's smallest metric is above 512, that value is subtracted from every metric computed in the next step, so decisions match unbounded arithmetic.
- R9: With `bm_valid` held high, consecutive symbols are accepted exactly 8 cycles apart.
- R10: `bm_data` values presented while `bm_ready` is 0 have no effect. Only the value on the accepting edge is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bm_valid | input | 1 | Branch metric set is valid |
| bm_ready | output | 1 | Block can take a branch metric set |
| bm_data | input | 16 | Four 4-bit branch metrics, lane c at bits 4c+3..4c |
| dec_valid | output | 1 | One-cycle strobe: step finished |
| dec_bits | output | 64 | Survivor decision per state, bit s for state s |
| best_state | output | 6 | Index of the lowest-metric state of the step |

## Verification
A wrong metric, wrong branch lane or wrong predecessor inside the sweep does not show up on the metric itself, because no metric is visible at the ports. It shows up as a flipped decision bit or a different `best_state` at the next `dec_valid` strobe, or within a few strobes once the error has spread through the trellis. A normalization fault stays hidden until the metrics pass half range, which can take many symbols. Once they do, it shows as decision disagreements across nearly every state. Handshake or sequencing faults appear within one step as a misplaced `bm_ready` or `dec_valid` edge. The bench therefore compares handshake pins every cycle and full outputs at every strobe against an unbounded-integer trellis model.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int CONSTR = 7;
  localparam int SW     = CONSTR - 1;
  localparam int NST    = 1 << SW;
  localparam logic [CONSTR-1:0] GEN_A = 7'b1111001;
  localparam logic [CONSTR-1:0] GEN_B = 7'b1011011;

  // coded bit pair emitted for a 7-bit encoder window, newest bit at the top
  function automatic logic [1:0] code_pair(input logic [CONSTR-1:0] win);
    return {^(win & GEN_A), ^(win & GEN_B)};
  endfunction
endpackage

// File: rtl/acs_lane.sv
module acs_lane #(
  parameter int MW  = 10,
  parameter int BMW = 4
) (
  input  logic [MW-1:0]  pm_even,
  input  logic [MW-1:0]  pm_odd,
  input  logic [BMW-1:0] bm_even,
  input  logic [BMW-1:0] bm_odd,
  input  logic [MW-1:0]  sub,
  output logic [MW-1:0]  new_m,
  output logic           pick_odd
);
  logic [MW:0] sum_e, sum_o, win, diff;

  always_comb begin
    sum_e    = {1'b0, pm_even} + {{(MW + 1 - BMW){1'b0}}, bm_even};
    sum_o    = {1'b0, pm_odd}  + {{(MW + 1 - BMW){1'b0}}, bm_odd};
    pick_odd = (sum_o < sum_e);
    win      = pick_odd ? sum_o : sum_e;
    diff     = win - {1'b0, sub};
    new_m    = diff[MW] ? {MW{1'b1}} : diff[MW-1:0];
  end
endmodule

// File: rtl/best_pick.sv
module best_pick #(
  parameter int LANES = 8,
  parameter int MW    = 10,
  parameter int IW    = 3
) (
  input  logic [LANES*MW-1:0] mets,
  output logic [MW-1:0]       min_m,
  output logic [IW-1:0]       min_l
);
  always_comb begin
    min_m = mets[MW-1:0];
    min_l = '0;
    for (int l = 1; l < LANES; l++) begin
      if (mets[l*MW +: MW] < min_m) begin
        min_m = mets[l*MW +: MW];
        min_l = IW'(l);
      end
    end
  end
endmodule

// File: rtl/trellis_acs_unit.sv
module trellis_acs_unit
  import acs_pkg::*;
#(
  parameter int MW       = 10,
  parameter int BMW      = 4,
  parameter int LANES    = 8,
  parameter int INIT_MET = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bm_valid,
  output logic             bm_ready,
  input  logic [4*BMW-1:0] bm_data,
  output logic             dec_valid,
  output logic [NST-1:0]   dec_bits,
  output logic [SW-1:0]    best_state
);
  localparam int GROUPS = NST / LANES;
  localparam int LW     = $clog2(LANES);
  localparam int GW     = SW - LW;
  localparam logic [MW-1:0] HALF = MW'(1 << (MW - 1));
  localparam logic [GW-1:0] LAST_G = GW'(GROUPS - 1);

  logic [MW-1:0]      pm [2][NST];
  logic               rd_sel;
  logic               busy;
  logic [GW-1:0]      grp;
  logic [4*BMW-1:0]   bm_q;
  logic [MW-1:0]      sub_q;
  logic [MW-1:0]      run_m;
  logic [SW-1:0]      run_i;
  logic [NST-1:0]     dec_q;
  logic [LANES*MW-1:0] lane_m;
  logic [LANES-1:0]   lane_d;
  logic [MW-1:0]      cand_m, fin_m;
  logic [LW-1:0]      cand_l;
  logic [SW-1:0]      fin_i;
  logic               last_grp, accept;

  assign last_grp = busy && (grp == LAST_G);
  assign bm_ready = !busy || last_grp;
  assign accept   = bm_valid && bm_ready;
  assign dec_bits = dec_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SW-1:0] st, pe, po;
    logic [1:0]    ce, co;
    assign st = {grp, LW'(l)};
    assign pe = {st[SW-2:0], 1'b0};
    assign po = {st[SW-2:0], 1'b1};
    assign ce = code_pair({st[SW-1], pe});
    assign co = code_pair({st[SW-1], po});
    acs_lane #(.MW(MW), .BMW(BMW)) u_acs (
      .pm_even (pm[rd_sel][pe]),
      .pm_odd  (pm[rd_sel][po]),
      .bm_even (bm_q[ce*BMW +: BMW]),
      .bm_odd  (bm_q[co*BMW +: BMW]),
      .sub     (sub_q),
      .new_m   (lane_m[l*MW +: MW]),
      .pick_odd(lane_d[l])
    );
  end

  best_pick #(.LANES(LANES), .MW(MW), .IW(LW)) u_best (
    .mets (lane_m),
    .min_m(cand_m),
    .min_l(cand_l)
  );

  // running minimum across groups; strict compare keeps the earlier (lower) index
  always_comb begin
    if (grp == '0 || cand_m < run_m) begin
      fin_m = cand_m;
      fin_i = {grp, cand_l};
    end else begin
      fin_m = run_m;
      fin_i = run_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NST; s++)
          pm[b][s] <= (s == 0) ? '0 : MW'(INIT_MET);
      rd_sel     <= 1'b0;
      busy       <= 1'b0;
      grp        <= '0;
      bm_q       <= '0;
      sub_q      <= '0;
      run_m      <= '0;
      run_i      <= '0;
      dec_q      <= '0;
      dec_valid  <= 1'b0;
      best_state <= '0;
    end else begin
      dec_valid <= last_grp;
      if (busy) begin
        for (int l = 0; l < LANES; l++) begin
          pm[!rd_sel][{grp, LW'(l)}] <= lane_m[l*MW +: MW];
          dec_q[{grp, LW'(l)}]       <= lane_d[l];
        end
        grp   <= grp + 1'b1;
        run_m <= fin_m;
        run_i <= fin_i;
      end
      if (last_grp) begin
        rd_sel     <= !rd_sel;
        best_state <= fin_i;
        sub_q      <= (fin_m > HALF) ? fin_m : '0;
      end
      if (accept) begin
        bm_q <= bm_data;
        busy <= 1'b1;
        grp  <= '0;
      end else if (last_grp) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acs_chk.sv
module acs_chk #(
  parameter int SW     = 6,
  parameter int GROUPS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bm_valid,
  input logic          bm_ready,
  input logic          dec_valid,
  input logic [SW-1:0] best_state
);
  localparam int CW = $clog2(GROUPS + 2);
  logic [CW-1:0] since_acc;
  logic          acc;
  assign acc = bm_valid && bm_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_acc <= '0;
    else if (acc) since_acc <= CW'(1);
    else if (since_acc != '0 && since_acc <= CW'(GROUPS)) since_acc <= since_acc + 1'b1;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !bm_ready);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> ($past(since_acc) == CW'(GROUPS)));

  // R7
  best_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> $stable(best_state));
endmodule

bind trellis_acs_unit acs_chk #(.SW(6), .GROUPS(8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bm_valid  (bm_valid),
  .bm_ready  (bm_ready),
  .dec_valid (dec_valid),
  .best_state(best_state)
);

// File: tb/trellis_acs_unit_tb.sv
module trellis_acs_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bm_valid;
  logic        bm_ready;
  logic [15:0] bm_data;
  logic        dec_valid;
  logic [63:0] dec_bits;
  logic [5:0]  best_state;

  always #2 clk = ~clk;

  trellis_acs_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bm_valid(bm_valid), .bm_ready(bm_ready),
    .bm_data(bm_data), .dec_valid(dec_valid), .dec_bits(dec_bits),
    .best_state(best_state)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rem = 0;
  int sub = 0;
  int last_acc = -1;
  bit b2b = 0;
  bit done_exp = 0;
  int om [64];
  logic [63:0] q_dec [$];
  int          q_best [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int lane_of(input int newest, input int prev);
    logic [6:0] w;
    w = 7'((newest << 6) | prev);
    return 2 * int'(^(w & 7'o171)) + int'(^(w & 7'o133));
  endfunction

  // behavioural reference: unbounded integer metrics, normalization by rule
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 64; s++) om[s] = (s == 0) ? 0 : 256;
      rem = 0; sub = 0; done_exp = 0;
    end else begin
      bit acc;
      cyc++;
      acc = bm_valid && (rem <= 1);
      done_exp = (rem == 1);
      if (rem > 0) rem--;
      if (acc) begin
        int nm [64];
        logic [63:0] d;
        int best, bi;
        for (int s = 0; s < 64; s++) begin
          int pe, po, se, so;
          pe = (s * 2) % 64;
          po = pe + 1;
          se = om[pe] + int'(bm_data[4*lane_of(s / 32, pe) +: 4]);
          so = om[po] + int'(bm_data[4*lane_of(s / 32, po) +: 4]);
          d[s] = (so < se);
          nm[s] = (d[s] ? so : se) - sub;
        end
        best = nm[0]; bi = 0;
        for (int s = 1; s < 64; s++) if (nm[s] < best) begin best = nm[s]; bi = s; end
        sub = (best > 512) ? best : 0;
        for (int s = 0; s < 64; s++) om[s] = nm[s];
        q_dec.push_back(d);
        q_best.push_back(bi);
        if (b2b && last_acc >= 0) chk((cyc - last_acc) == 8, "R9 accept spacing", 64'(cyc - last_acc), 64'd8);
        last_acc = cyc;
        rem = 8;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(bm_ready == (rem <= 1), "R2 bm_ready", 64'(bm_ready), 64'(rem <= 1));
      chk(dec_valid == done_exp, "R3 dec_valid", 64'(dec_valid), 64'(done_exp));
      if (done_exp && q_dec.size() > 0) begin
        logic [63:0] ed;
        int eb;
        ed = q_dec.pop_front();
        eb = q_best.pop_front();
        chk(dec_bits == ed, "R4 R5 R6 R8 R10 dec_bits", dec_bits, ed);
        chk(int'(best_state) == eb, "R7 R8 best_state", 64'(best_state), 64'(eb));
      end
    end
  end

  task automatic send(input logic [15:0] d, input int gap, input bit junk);
    bm_valid = 1'b1;
    bm_data  = d;
    while (!bm_ready) begin
      @(negedge clk);
      if (junk) bm_data = 16'($urandom);
    end
    @(negedge clk);
    if (gap > 0) begin
      bm_valid = 1'b0;
      bm_data  = 16'($urandom);
      repeat (gap) @(negedge clk);
    end
  endtask

  function automatic logic [15:0] rnd_bm(input int lo, input int hi);
    logic [15:0] v;
    for (int k = 0; k < 4; k++) v[4*k +: 4] = 4'(lo + int'($urandom % 32'(hi - lo + 1)));
    return v;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        checks++; errors++;
        $display("FAIL R3 watchdog: actual %0d cycles expected completion", wd);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0; bm_valid = 1'b0; bm_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state at the ports
    chk(bm_ready == 1'b1, "R1 ready after reset", 64'(bm_ready), 64'd1);
    chk(dec_valid == 1'b0, "R1 done after reset", 64'(dec_valid), 64'd0);
    chk(best_state == '0, "R1 best after reset", 64'(best_state), 64'd0);
    chk(dec_bits == '0, "R1 dec after reset", dec_bits, 64'd0);
    // first steps from the reset metrics, all-zero then equal metrics (ties, R6)
    send(16'h0000, 3, 0);
    send(16'h3333, 2, 0);
    send(16'h0000, 1, 0);
    // distinct lanes exercise branch selection (R4)
    send(16'h0F00, 2, 0);
    send(16'hF000, 2, 0);
    send(16'h000F, 2, 0);
    for (int i = 0; i < 20; i++) send(rnd_bm(0, 15), 1 + (i % 3), 0);
    // back-to-back streaming with junk data while not ready (R9, R10)
    send(rnd_bm(0, 15), 0, 1);
    b2b = 1;
    for (int i = 0; i < 60; i++) send(rnd_bm(0, 15), 0, 1);
    b2b = 0;
    bm_valid = 1'b0;
    repeat (5) @(negedge clk);
    // metrics climb past half range repeatedly (R8)
    for (int i = 0; i < 250; i++) send(rnd_bm(6, 15), 0, 1);
    bm_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(q_dec.size() == 0, "R3 all steps reported", 64'(q_dec.size()), 64'd0);
    finish_run();
  end
endmodule